// File: doc/BRIEF.md
# Phase-One SPI Slave Receiver/Transmitter

This block is the slave end of an SPI link that uses clock phase one: each byte moves eight bits, most significant bit first, over a serial clock, a data-in line, a data-out line and an active-low select. The serial pins are asynchronous to the block. They are brought into the system clock domain through a two-flop synchroniser, and all edge detection happens on the synchronised copies. The system clock must run at least four times faster than the serial clock.

A byte starts at the first serial clock edge seen while select is low, not at the falling edge of select. Odd edges, which leave the idle level, move the next transmit bit onto the data-out line. Even edges capture the data-in line. The received byte is reported with a single-cycle valid pulse as soon as its eighth bit is captured. Select may stay low across any number of bytes.

Local logic supplies each transmit byte with a one-cycle load strobe. The byte is taken into a holding register and used at the start of the next byte. If no fresh byte is waiting at that point, the previous byte is sent again and an overrun flag is raised. Raising select in the middle of a byte abandons that byte.

Top module: `spi_cpha1_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `miso` is 0, `rx_valid` is 0, `rx_byte` is 0 and `tx_overrun` is 0.
- R2: A byte begins at the first leading serial clock edge seen while `sel_n` is low. A falling `sel_n` alone does not change `miso`.
- R3: Each leading edge drives the next transmit bit onto `miso`, most significant bit first. Each trailing edge shifts `mosi` in, most significant bit first. The first received bit ends up in `rx_byte[7]`.
- R4: Every pin change takes effect at the outputs on the third rising system clock edge after it: two synchroniser stages plus one output register.
- R5: `rx_valid` is high for exactly one cycle per byte, in the cycle after the eighth trailing edge is processed, and `rx_byte` holds that byte until the next pulse.
- R6: With `sel_n` held low, bytes follow each other with no toggling of select. The bit count restarts after every eighth capture.
- R7: Between bytes and before the first edge of a byte, `miso` keeps the last bit sent, which is the LSB of the previous byte (0 after reset).
- R8: When `cpol` is 0 the idle level is low, so rising edges lead and falling edges trail. When `cpol` is 1 the idle level is high, so falling edges lead and rising edges trail.
- R9: A rise of `sel_n` in mid-byte abandons the byte. No `rx_valid` pulse follows, and the next leading edge with select low starts a new byte.
- R10: Serial clock edges while `sel_n` is high change neither `miso` nor `rx_byte`, and they produce no `rx_valid`.
- R11: A one-cycle `tx_load` pulse stores `tx_byte` in a holding register. That value is sent in the next byte that starts.
- R12: If no byte has been loaded since the last byte started, the next byte resends the previous transmit byte and `tx_overrun` goes to 1. `tx_overrun` returns to 0 at the next byte start that finds a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level (0 low, 1 high) |
| sck | input | 1 | Serial clock from the master, asynchronous |
| mosi | input | 1 | Serial data from the master, asynchronous |
| sel_n | input | 1 | Active-low slave select, asynchronous |
| tx_byte | input | 8 | Next byte to transmit |
| tx_load | input | 1 | One-cycle strobe that stores `tx_byte` |
| miso | output | 1 | Serial data to the master |
| rx_byte | output | 8 | Last completely received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| tx_overrun | output | 1 | Previous byte was resent for lack of a new one |

## Verification
A wrong bit counter shows up as an `rx_valid` pulse in the wrong cycle or a missing one, and this is visible no later than three system cycles after the eighth trailing edge of the affected byte. A wrong transmit shift register or source choice shows up on `miso` three cycles after the first leading edge that uses it. A stale in-byte flag after an abort or a polarity switch shows up at the start of the next byte, as a wrong first `miso` bit or a wrong `tx_overrun` level. The bench predicts `miso`, `rx_valid`, `rx_byte` and `tx_overrun` for every cycle, so any such deviation is caught in the first cycle it appears.

// File: rtl/spi_cpha1_slave.sv
module spi_cpha1_slave #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         sck,
  input  logic         mosi,
  input  logic         sel_n,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_load,
  output logic         miso,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         tx_overrun
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  logic [SYNC-1:0] sck_p, mosi_p, seln_p;
  logic            sck_s, mosi_s, sel_act, sck_q;
  logic            rise, fall, lead_ev, trail_ev, start;
  logic            in_byte, hold_full;
  logic [CW-1:0]   bit_cnt;
  logic [W-1:0]    hold, last_tx, txsr, rxsr, src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      mosi_p <= '0;
      seln_p <= '1;
      sck_q  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC-2:0], sck};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
      seln_p <= {seln_p[SYNC-2:0], sel_n};
      sck_q  <= sck_s;
    end
  end

  assign sck_s    = sck_p[SYNC-1];
  assign mosi_s   = mosi_p[SYNC-1];
  assign sel_act  = ~seln_p[SYNC-1];
  assign rise     = sck_s & ~sck_q;
  assign fall     = ~sck_s & sck_q;
  assign lead_ev  = cpol ? fall : rise;
  assign trail_ev = cpol ? rise : fall;
  assign start    = sel_act & lead_ev & ~in_byte;
  assign src      = tx_load ? tx_byte : (hold_full ? hold : last_tx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (tx_load && !start) begin
      hold      <= tx_byte;
      hold_full <= 1'b1;
    end else if (start) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_byte    <= 1'b0;
      bit_cnt    <= '0;
      txsr       <= '0;
      rxsr       <= '0;
      last_tx    <= '0;
      miso       <= 1'b0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      tx_overrun <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!sel_act) begin
        in_byte <= 1'b0;
        bit_cnt <= '0;
      end else if (lead_ev) begin
        if (!in_byte) begin
          in_byte    <= 1'b1;
          miso       <= src[W-1];
          txsr       <= {src[W-2:0], 1'b0};
          last_tx    <= src;
          tx_overrun <= ~(tx_load | hold_full);
        end else begin
          miso <= txsr[W-1];
          txsr <= {txsr[W-2:0], 1'b0};
        end
      end else if (trail_ev && in_byte) begin
        rxsr <= {rxsr[W-2:0], mosi_s};
        if (bit_cnt == LAST_BIT) begin
          rx_byte  <= {rxsr[W-2:0], mosi_s};
          rx_valid <= 1'b1;
          bit_cnt  <= '0;
          in_byte  <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cpha1_slave_chk.sv
module spi_cpha1_slave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_act,
  input logic         lead_ev,
  input logic         trail_ev,
  input logic         miso,
  input logic [W-1:0] rx_byte,
  input logic         rx_valid,
  input logic         tx_overrun
);
  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  valid_after_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(trail_ev && sel_act));

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);

  // R3
  miso_on_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(lead_ev && sel_act));

  // R10
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> $stable(miso));

  // R9
  no_valid_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> !rx_valid);

  // R12
  overrun_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_overrun) |-> $past(lead_ev && sel_act));
endmodule

bind spi_cpha1_slave spi_cpha1_slave_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_act   (sel_act),
  .lead_ev   (lead_ev),
  .trail_ev  (trail_ev),
  .miso      (miso),
  .rx_byte   (rx_byte),
  .rx_valid  (rx_valid),
  .tx_overrun(tx_overrun)
);

// File: tb/spi_cpha1_slave_tb.sv
module spi_cpha1_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       sel_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_load = 1'b0;
  logic       miso, rx_valid, tx_overrun;
  logic [7:0] rx_byte;

  spi_cpha1_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .sck(sck), .mosi(mosi),
    .sel_n(sel_n), .tx_byte(tx_byte), .tx_load(tx_load), .miso(miso),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_overrun(tx_overrun)
  );

  always #5 clk = ~clk;

  int    tests = 0, fails = 0, pcount = 0;
  bit    run = 0, done = 0;
  string tag = "R1";

  int q_due[$], q_kind[$], q_val[$];
  logic       e_miso = 0, e_ovr = 0, e_valid = 0;
  logic [7:0] e_rxb = 0;

  logic       m_in = 0, m_full = 0;
  logic [7:0] m_hold = 0, m_last = 0, m_sh = 0, m_rx = 0;
  int         m_nxt = 0, m_cnt = 0;

  always @(posedge clk) pcount <= pcount + 1;

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h @%0d", tag, what, act, exp, pcount);
    end
  endtask

  task automatic push(int kind, int val);
    q_due.push_back(pcount + 3);  // R4: two sync stages plus output register
    q_kind.push_back(kind);
    q_val.push_back(val);
  endtask

  always @(negedge clk) begin
    if (run) begin
      e_valid = 0;
      while (q_due.size() > 0 && q_due[0] <= pcount) begin
        case (q_kind[0])
          0: e_miso = q_val[0][0];
          1: e_ovr  = q_val[0][0];
          default: begin e_valid = 1; e_rxb = q_val[0][7:0]; end
        endcase
        void'(q_due.pop_front()); void'(q_kind.pop_front()); void'(q_val.pop_front());
      end
      chk("miso", miso, e_miso);
      chk("rx_valid", rx_valid, e_valid);
      chk("rx_byte", rx_byte, e_rxb);
      chk("tx_overrun", tx_overrun, e_ovr);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic m_lead();
    if (sel_n) return;
    if (!m_in) begin
      logic [7:0] s;
      s = m_full ? m_hold : m_last;
      push(1, m_full ? 0 : 1);
      m_full = 0; m_last = s; m_sh = s; m_in = 1; m_nxt = 6;
      push(0, s[7]);
    end else if (m_nxt >= 0) begin
      push(0, m_sh[m_nxt]);
      m_nxt--;
    end
  endtask

  task automatic m_trail(logic b);
    if (sel_n || !m_in) return;
    m_rx = {m_rx[6:0], b};
    m_cnt++;
    if (m_cnt == 8) begin
      push(2, m_rx);
      m_cnt = 0; m_in = 0;
    end
  endtask

  task automatic drive_sck(logic v);
    logic lead;
    lead = cpol ? (v == 1'b0) : (v == 1'b1);
    sck = v;
    if (lead) m_lead(); else m_trail(mosi);
  endtask

  task automatic set_sel(logic v);
    sel_n = v;
    if (v) begin m_in = 0; m_cnt = 0; end
  endtask

  task automatic load(logic [7:0] b);
    tx_byte = b; tx_load = 1'b1;
    m_hold = b; m_full = 1;
    step(1);
    tx_load = 1'b0;
    step(4);
  endtask

  task automatic send(logic [7:0] b, int nbits);
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7-i];
      drive_sck(~sck);
      step(4);
      drive_sck(~sck);
      step(4);
    end
    step(6);
  endtask

  initial begin
    step(3);
    tag = "R1";
    chk("reset miso", miso, 0);
    chk("reset rx_valid", rx_valid, 0);
    chk("reset rx_byte", rx_byte, 0);
    chk("reset tx_overrun", tx_overrun, 0);
    rst_n = 1'b1;
    step(1);
    chk("post-reset miso", miso, 0);
    chk("post-reset tx_overrun", tx_overrun, 0);
    run = 1;
    step(4);

    tag = "R2 R3 R4 R11";
    load(8'hA5);
    set_sel(1'b0);
    step(8);
    send(8'h3C, 8);

    tag = "R5 R6 R7";
    load(8'h5A);
    send(8'hC3, 8);
    step(10);

    tag = "R12";
    send(8'h81, 8);
    load(8'h0F);
    send(8'h7E, 8);

    tag = "R9";
    load(8'hF0);
    send(8'hAA, 4);
    set_sel(1'b1);
    step(10);
    set_sel(1'b0);
    step(6);
    load(8'h22);
    send(8'h99, 8);

    tag = "R10";
    set_sel(1'b1);
    step(6);
    send(8'h55, 8);
    step(6);

    tag = "R8";
    cpol = 1'b1; sck = 1'b1;
    step(8);
    load(8'h6D);
    set_sel(1'b0);
    step(6);
    send(8'hB4, 8);
    load(8'h01);
    send(8'h80, 8);
    set_sel(1'b1);
    step(8);

    run = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=done", pcount);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule